// File: doc/BRIEF.md
# Phase-Offset Sine Oscillator

This block is a numerically controlled oscillator that turns a reference clock into a stream of cosine samples for a downstream digital-to-analog converter. A 32-bit phase register adds a frequency tuning word on every clock and wraps modulo 2^32. The output frequency is therefore the tuning word times the clock rate divided by 2^32. Only settings below half the clock rate give a useful tone.

A 5-bit coarse phase offset is added to the top five bits of the phase as it is read out. The offset weights are 180, 90, 45, 22.5 and 11.25 degrees. The stored phase itself is never changed by the offset. The summed phase is cut down to 14 bits. From it the block produces a signed 10-bit cosine sample. It uses a quarter-wave table of 257 magnitudes plus linear interpolation, and builds the other three quadrants from symmetry.

Changing the tuning word never clears the phase, so the waveform stays continuous. A power-down input freezes the phase and silences the output.

A small control state machine sequences the block:
- ST_PRIME is entered on reset and when power-down ends. It waits while the pipeline fills.
- ST_RUN drives valid samples.
- ST_SLEEP is entered while power-down is asserted.

Its transitions are:
- PRIME_TO_RUN: the fill count is complete and power-down is low.
- PRIME_TO_SLEEP: power-down is high.
- RUN_TO_SLEEP: power-down is high.
- SLEEP_TO_PRIME: power-down is low.

Top module: `pofs_nco`

## Requirements
- R1: On each clock edge with reset and power-down low, the 32-bit phase increases by `ftw_i` modulo 2^32. A word of 0x8000_0000 alternates the output between +511 and -511.
- R2: Only the upper 14 bits of the offset phase select the output. Phase changes below bit 18 do not move the sample.
- R3: `pofs_i` is added to phase bits [31:27] at readout only. Bit 4 weighs 180 degrees and bit 0 weighs 11.25 degrees. Returning `pofs_i` to an earlier value restores the earlier sample.
- R4: `sample_o` is two's complement and lies within 2 LSB of round(511*cos(2*pi*p/16384)), where p is the 14-bit phase. The value -512 never appears while valid.
- R5: A change of `ftw_i` does not reset the phase. Accumulation continues from the value already reached.
- R6: A tuning word sampled at edge t reaches `sample_o` after edge t+3. A phase offset sampled at edge t reaches it after edge t+2.
- R7: `valid_o` first goes high after the third edge that follows the release of reset (state ST_PRIME then ST_RUN). It is high only when the previous state was ST_RUN.
- R8: While `pdn_i` is sampled high, the phase holds its value. From the second edge after the first high sample, `sample_o` is 0 and `valid_o` is low (ST_SLEEP). After `pdn_i` is sampled low at edge x, the phase resumes from its held value and `valid_o` returns after edge x+3.
- R9: A tuning word of zero with a fixed offset gives a constant output.
- R10: A synchronous active-high reset clears the phase to zero and drives `sample_o` to 0 and `valid_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_i | input | 1 | Synchronous reset, active high |
| ftw_i | input | 32 | Frequency tuning word |
| pofs_i | input | 5 | Coarse phase offset, bit 4 = 180 degrees |
| pdn_i | input | 1 | Power-down: hold phase, silence output |
| sample_o | output | 10 | Signed cosine sample |
| valid_o | output | 1 | Sample is valid |

## Verification
The latencies differ by input:
- A tuning word reaches the sample three edges after it is sampled.
- A phase offset reaches the sample two edges after it is sampled.
- After reset release, or when power-down ends, valid returns on the third edge.
- On entry to power-down, silence starts on the second edge.

The bench keeps a cycle model of the phase, with a two-stage delay line and an edge counter for valid. The model is updated at the rising edge, and the outputs are compared at the falling edge of every cycle. A single-cycle pulse on either input therefore only matches the model if it lands on exactly the required edge. The bench sweeps every 14-bit phase and all 32 offsets.

// File: rtl/nco_pkg.sv
`timescale 1ns/1ps
package nco_pkg;
    typedef enum logic [1:0] {
        ST_PRIME = 2'd0,
        ST_RUN   = 2'd1,
        ST_SLEEP = 2'd2
    } nco_state_e;

    localparam int PIPE_DEPTH = 3;
endpackage

// File: rtl/nco_phase_acc.sv
`timescale 1ns/1ps
module nco_phase_acc #(
    parameter int ACC_W   = 32,
    parameter int OFS_W   = 5,
    parameter int TRUNC_W = 14
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               hold,
    input  logic [ACC_W-1:0]   step,
    input  logic [OFS_W-1:0]   ofs,
    output logic [TRUNC_W-1:0] phase_q
);
    localparam int SHIFT = ACC_W - TRUNC_W;

    logic [ACC_W-1:0] acc_q;
    logic [ACC_W-1:0] ofs_ext;
    logic [ACC_W-1:0] sum;

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
        end else if (!hold) begin
            acc_q <= acc_q + step;
        end
    end

    always_comb begin
        ofs_ext = {ofs, {(ACC_W-OFS_W){1'b0}}};
        sum     = acc_q + ofs_ext;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= '0;
        end else begin
            phase_q <= TRUNC_W'(sum >> SHIFT);
        end
    end

    // R8: phase frozen while held
    p_hold_freeze_r8: assert property (@(posedge clk) disable iff (rst)
        hold |=> acc_q == $past(acc_q));

    // R9: zero tuning word keeps the phase fixed
    p_zero_step_r9: assert property (@(posedge clk) disable iff (rst)
        (step == '0) |=> acc_q == $past(acc_q));
endmodule

// File: rtl/nco_quarter_fold.sv
`timescale 1ns/1ps
module nco_quarter_fold #(
    parameter int TRUNC_W = 14,
    parameter int AMP_W   = 10,
    parameter int TAB_AW  = 8
) (
    input  logic                                clk,
    input  logic                                rst,
    input  logic [TRUNC_W-1:0]                  phase,
    output logic [AMP_W-2:0]                    lo_q,
    output logic [AMP_W-2:0]                    hi_q,
    output logic [TRUNC_W-3-TAB_AW:0]           frac_q,
    output logic                                neg_q
);
    localparam int QTR_W   = TRUNC_W - 2;
    localparam int FRAC_W  = QTR_W - TAB_AW;
    localparam int TAB_N   = 1 << TAB_AW;
    localparam int MAG_W   = AMP_W - 1;
    localparam int AMP_MAX = (1 << (AMP_W - 1)) - 1;
    localparam real HALF_PI = 1.5707963267948966;

    logic [MAG_W-1:0] tab [0:TAB_N];

    for (genvar k = 0; k <= TAB_N; k++) begin : g_tab
        localparam real ANG = HALF_PI * k / TAB_N;
        localparam int  VAL = int'(AMP_MAX * $cos(ANG));
        assign tab[k] = MAG_W'(VAL);
    end

    logic [1:0]        quad;
    logic [QTR_W-1:0]  rem;
    logic [QTR_W:0]    u;
    logic [TAB_AW:0]   idx;
    logic [TAB_AW:0]   idx_n;
    logic              neg;

    always_comb begin
        quad  = phase[TRUNC_W-1 -: 2];
        rem   = phase[QTR_W-1:0];
        u     = quad[0] ? ((QTR_W+1)'(1) << QTR_W) - {1'b0, rem} : {1'b0, rem};
        idx   = u[QTR_W:FRAC_W];
        idx_n = (idx == (TAB_AW+1)'(TAB_N)) ? idx : idx + (TAB_AW+1)'(1);
        neg   = quad[1] ^ quad[0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lo_q   <= '0;
            hi_q   <= '0;
            frac_q <= '0;
            neg_q  <= 1'b0;
        end else begin
            lo_q   <= tab[idx];
            hi_q   <= tab[idx_n];
            frac_q <= u[FRAC_W-1:0];
            neg_q  <= neg;
        end
    end

    // R4: cosine magnitude never rises within a quarter
    p_mag_order_r4: assert property (@(posedge clk) disable iff (rst)
        hi_q <= lo_q);
endmodule

// File: rtl/nco_interp.sv
`timescale 1ns/1ps
module nco_interp #(
    parameter int AMP_W  = 10,
    parameter int FRAC_W = 4
) (
    input  logic [AMP_W-2:0]  lo,
    input  logic [AMP_W-2:0]  hi,
    input  logic [FRAC_W-1:0] frac,
    input  logic              neg,
    output logic [AMP_W-1:0]  sample
);
    localparam int MAG_W  = AMP_W - 1;
    localparam int PROD_W = MAG_W + FRAC_W;

    logic [MAG_W-1:0]  diff;
    logic [PROD_W-1:0] prod;
    logic [MAG_W-1:0]  drop;
    logic [MAG_W-1:0]  mag;

    always_comb begin
        diff   = lo - hi;
        prod   = PROD_W'(diff) * PROD_W'(frac);
        drop   = MAG_W'(prod >> FRAC_W);
        mag    = lo - drop;
        sample = neg ? AMP_W'(0) - {1'b0, mag} : {1'b0, mag};
    end
endmodule

// File: rtl/pofs_nco.sv
`timescale 1ns/1ps
module pofs_nco
    import nco_pkg::*;
#(
    parameter int ACC_W   = 32,
    parameter int OFS_W   = 5,
    parameter int TRUNC_W = 14,
    parameter int AMP_W   = 10,
    parameter int TAB_AW  = 8
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic [31:0]      ftw_i,
    input  logic [4:0]       pofs_i,
    input  logic             pdn_i,
    output logic [9:0]       sample_o,
    output logic             valid_o
);
    localparam int FRAC_W    = TRUNC_W - 2 - TAB_AW;
    localparam int FILL_W    = $clog2(PIPE_DEPTH);
    localparam int FILL_LAST = PIPE_DEPTH - 2;

    nco_state_e       state_q, state_d;
    logic [FILL_W-1:0] fill_q, fill_d;

    logic [TRUNC_W-1:0] phase;
    logic [AMP_W-2:0]   lo, hi;
    logic [FRAC_W-1:0]  frac;
    logic               neg;
    logic [AMP_W-1:0]   interp;

    nco_phase_acc #(.ACC_W(ACC_W), .OFS_W(OFS_W), .TRUNC_W(TRUNC_W)) u_acc (
        .clk    (clk_i),
        .rst    (rst_i),
        .hold   (pdn_i),
        .step   (ftw_i),
        .ofs    (pofs_i),
        .phase_q(phase)
    );

    nco_quarter_fold #(.TRUNC_W(TRUNC_W), .AMP_W(AMP_W), .TAB_AW(TAB_AW)) u_fold (
        .clk   (clk_i),
        .rst   (rst_i),
        .phase (phase),
        .lo_q  (lo),
        .hi_q  (hi),
        .frac_q(frac),
        .neg_q (neg)
    );

    nco_interp #(.AMP_W(AMP_W), .FRAC_W(FRAC_W)) u_interp (
        .lo    (lo),
        .hi    (hi),
        .frac  (frac),
        .neg   (neg),
        .sample(interp)
    );

    // state register
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            state_q <= ST_PRIME;
            fill_q  <= '0;
        end else begin
            state_q <= state_d;
            fill_q  <= fill_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        fill_d  = fill_q;
        unique case (state_q)
            ST_PRIME: begin
                if (pdn_i) begin
                    state_d = ST_SLEEP;              // PRIME_TO_SLEEP
                    fill_d  = '0;
                end else if (fill_q == FILL_W'(FILL_LAST)) begin
                    state_d = ST_RUN;                // PRIME_TO_RUN
                    fill_d  = '0;
                end else begin
                    fill_d  = fill_q + FILL_W'(1);
                end
            end
            ST_RUN: begin
                if (pdn_i) state_d = ST_SLEEP;       // RUN_TO_SLEEP
            end
            ST_SLEEP: begin
                if (!pdn_i) begin
                    state_d = ST_PRIME;              // SLEEP_TO_PRIME
                    fill_d  = '0;
                end
            end
            default: begin
                state_d = ST_PRIME;
                fill_d  = '0;
            end
        endcase
    end

    // outputs
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            sample_o <= '0;
            valid_o  <= 1'b0;
        end else begin
            unique case (state_q)
                ST_RUN: begin
                    sample_o <= interp;
                    valid_o  <= 1'b1;
                end
                default: begin
                    sample_o <= '0;
                    valid_o  <= 1'b0;
                end
            endcase
        end
    end

    // R8: sleep gives a silent, invalid output
    p_sleep_quiet_r8: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_q == ST_SLEEP) |=> (sample_o == '0 && !valid_o));

    // R7: valid only follows the run state
    p_valid_from_run_r7: assert property (@(posedge clk_i) disable iff (rst_i)
        valid_o |-> $past(state_q) == ST_RUN);

    // R7: fill count stays within the pipeline depth
    p_fill_bound_r7: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_q == ST_PRIME) |-> fill_q <= FILL_W'(FILL_LAST));

    // R4: symmetric amplitude, most negative code unused
    p_sample_range_r4: assert property (@(posedge clk_i) disable iff (rst_i)
        valid_o |-> sample_o != {1'b1, {(AMP_W-1){1'b0}}});
endmodule

// File: tb/pofs_nco_tb_top.sv
`timescale 1ns/1ps
module pofs_nco_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] ftw = '0;
    logic [4:0]  pw  = '0;
    logic        pd  = 1'b0;
    logic [9:0]  smp;
    logic        vld;

    always #2.5 clk = ~clk;

    pofs_nco dut_i (
        .clk_i   (clk),
        .rst_i   (rst),
        .ftw_i   (ftw),
        .pofs_i  (pw),
        .pdn_i   (pd),
        .sample_o(smp),
        .valid_o (vld)
    );

    int    checks = 0;
    int    errors = 0;
    string cur_req = "R10";
    bit    done = 1'b0;

    // reference model, updated at the rising edge
    logic [31:0] m_acc = '0;
    logic [13:0] m_ph  = '0;
    logic [13:0] m_s2  = '0;
    int          ok    = 0;
    int          exp_s = 0;
    bit          exp_v = 1'b0;
    int          act;
    int          held;

    function automatic int cos_ref(logic [13:0] p);
        real a;
        a = 6.283185307179586 * real'(p) / 16384.0;
        return int'(511.0 * $cos(a));
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_acc = '0; m_ph = '0; m_s2 = '0;
            ok = 1; exp_s = 0; exp_v = 1'b0;
        end else begin
            exp_v = (ok >= 3);
            exp_s = exp_v ? cos_ref(m_s2) : 0;
            m_s2  = m_ph;
            m_ph  = 14'((m_acc + {pw, 27'd0}) >> 18);
            if (!pd) begin
                m_acc = m_acc + ftw;
                ok    = (ok < 3) ? ok + 1 : 3;
            end else begin
                ok    = 0;
            end
        end
    end

    // per-cycle comparison away from the active edge
    always @(negedge clk) begin
        if (!done) begin
            checks++;
            act = int'($signed(smp));
            if (vld !== exp_v ||
                (exp_v ? (act - exp_s > 2 || exp_s - act > 2) : (act != 0))) begin
                errors++;
                $display("FAIL %s: sample=%0d valid=%0b expected sample=%0d valid=%0b t=%0t",
                         cur_req, act, vld, exp_s, exp_v, $time);
            end
        end
    end

    task automatic check_eq(string req, int actual, int expected);
        checks++;
        if (actual != expected) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d t=%0t", req, actual, expected, $time);
        end
    endtask

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        // R10: reset state
        step(4);
        check_eq("R10", int'($signed(smp)), 0);
        check_eq("R10", int'(vld), 0);
        rst = 1'b0;

        // R7: valid after fill
        cur_req = "R7";
        step(6);

        // R3: all offsets with the phase frozen at zero
        cur_req = "R3";
        for (int k = 0; k < 32; k++) begin
            pw = 5'(k);
            step(4);
        end
        pw = 5'd0;
        step(4);
        check_eq("R3", int'($signed(smp)), 511);

        // R6: single-cycle pulses on offset and tuning word
        cur_req = "R6";
        pw = 5'd8;
        step(1);
        pw = 5'd0;
        ftw = 32'h0400_0000;
        step(1);
        ftw = '0;
        step(6);

        // R9: zero tuning word holds the output
        cur_req = "R9";
        pw = 5'd5;
        step(5);
        held = int'($signed(smp));
        step(20);
        check_eq("R9", int'($signed(smp)), held);
        pw = 5'd0;
        step(3);

        // R1: wrap and Nyquist alternation
        cur_req = "R1";
        ftw = 32'h8000_0000;
        step(12);
        ftw = 32'hF000_0000;
        step(20);

        // R4: every 14-bit phase once
        cur_req = "R4";
        ftw = 32'h0004_0000;
        step(16400);

        // R2: sub-LSB steps
        cur_req = "R2";
        ftw = 32'h0000_8000;
        step(300);
        ftw = 32'h0003_FFFF;
        step(300);

        // R5: tuning changes mid-stream
        cur_req = "R5";
        begin
            logic [31:0] lcg;
            lcg = 32'h1357_9BDF;
            for (int k = 0; k < 8; k++) begin
                lcg = lcg * 32'd1664525 + 32'd1013904223;
                ftw = {2'b00, lcg[29:0]};
                step(37);
            end
        end

        // R8: power-down hold, glitch, and power-down during fill
        cur_req = "R8";
        ftw = 32'h0123_4567;
        step(10);
        pd = 1'b1;
        step(10);
        check_eq("R8", int'(vld), 0);
        pd = 1'b0;
        step(10);
        pd = 1'b1;
        step(1);
        pd = 1'b0;
        step(10);
        pd = 1'b1;
        step(3);
        pd = 1'b0;
        step(1);
        pd = 1'b1;
        step(2);
        pd = 1'b0;
        step(10);

        // R10: reset during operation
        cur_req = "R10";
        rst = 1'b1;
        step(3);
        check_eq("R10", int'($signed(smp)), 0);
        check_eq("R10", int'(vld), 0);
        rst = 1'b0;
        step(8);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule